// File: doc/BRIEF.md
# Command-List Memory Move Engine

The block is a small programmable copy engine that interprets a short command list held in a 16 KiB local memory. A program can load a 32-bit operand word, copy a counted run of words from one local address to another (with an optional bitwise AND against the operand on every word), and end. Addresses in a program use the engine's view of local memory, a window starting at 0xF0000000. Any fetch or copy that would leave the window, a misaligned address, a byte count that is not a multiple of four, or an unrecognised command word parks the engine in an error state until software resets it.

Software drives the block through a small register file selected by a 3-bit register index: a control/status register (run state in bits 31:30, soft reset on bit 16), a start-pointer register whose write launches a program, a memory-enable register, an address/data window for writing words into local memory, and a read-only identity register. The local memory itself sits outside the block behind a word-addressed port with a fixed one-cycle read latency. The engine owns that port while it runs; host window writes use it otherwise.

Top module: `cmdlist_mover`

## Requirements
- R1: After reset the status register (index 0) reads 0x80002AAA, the identity register (index 5) reads 0x00000102, the memory-enable register (index 2) reads 0 and the memory port makes no request.
- R2: A write to the window-address register (index 3) sets the byte offset whose bits 13:2 select the word; a write to the window-data register (index 4) while memory is enabled and the engine is not running drives a port write of that word in the same cycle; with memory disabled it makes no port access.
- R3: A write to the start register (index 1) while idle with memory enabled sets status bits 31:30 to 2'b11 from the next cycle and fetches commands from the written address; with memory disabled it sets the error code 2'b01 instead.
- R4: The command word 0x00000000 ends the run; the status register then reads 0x80002AAA (bits 31:30 = 2'b10).
- R5: The command word 0x06000000 makes the engine latch the following word as the AND operand.
- R6: A move command has bits 31:22 and 20 equal to those of 0x0A800000, the byte count in bits 19:0, and is followed by a source address word and a destination address word; it copies count/4 words in ascending address order, so an overlapping forward copy replicates the first source word; a count of 0 writes nothing.
- R7: When bit 21 of a move command is 1 each copied word is ANDed with the latched operand before it is written; when it is 0 the word is copied unchanged.
- R8: Any other command word (including a move pattern with bit 20 set) stops the engine with status bits 31:30 = 2'b01 (status 0x40002AAA); the error code persists, and start writes are ignored, until a soft reset.
- R9: A command fetch outside 0xF0000000..0xF0003FFF, or a move whose source or destination run leaves that window, is misaligned, or has a count not a multiple of 4, sets the error code and the move writes nothing.
- R10: Writing 1 to bit 16 of the control register returns the block from any state to its reset values on the next cycle (status 0x80002AAA, memory disabled), aborting a run in progress.
- R11: Writes to the identity register have no effect; it always reads 0x00000102.
- R12: Window-data writes issued while the engine is running are dropped and do not reach local memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register index for reads and writes |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr (combinational) |
| lm_req | output | 1 | Local memory access request |
| lm_we | output | 1 | Local memory write enable (0 = read) |
| lm_addr | output | 12 | Local memory word index |
| lm_wdata | output | 32 | Local memory write data |
| lm_rdata | input | 32 | Local memory read data, valid the cycle after a read request |

## Verification
The bound checker watches, on every cycle, that the run-state code never takes the unused value 2'b00, that the error code holds until a soft reset, that a start from idle always leaves idle and a soft reset always lands in idle with memory disabled, that the memory port stays silent whenever neither the engine runs nor a permitted window write occurs, and that the identity register never changes. Only the bench's programs can show the data results: AND and plain copies across a sweep of counts from 0 to 8 words, ascending order on an overlapping copy, the exact end of each run, the many ways a program reaches the error state without touching memory, and an aborted run leaving its tail unwritten.

// File: rtl/cme_pkg.sv
package cme_pkg;

  localparam int unsigned REG_AW = 3;

  // Register indices on the host interface
  localparam logic [REG_AW-1:0] REG_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] REG_START   = 3'd1;
  localparam logic [REG_AW-1:0] REG_MEMCTL  = 3'd2;
  localparam logic [REG_AW-1:0] REG_WINADDR = 3'd3;
  localparam logic [REG_AW-1:0] REG_WINDATA = 3'd4;
  localparam logic [REG_AW-1:0] REG_IDENT   = 3'd5;

  localparam int unsigned SOFT_RST_BIT = 16;
  localparam int unsigned AND_BIT      = 21;

  localparam logic [31:0] CMD_STOP = 32'h0000_0000;
  localparam logic [31:0] CMD_INIT = 32'h0600_0000;
  localparam logic [31:0] CMD_MOVE = 32'h0A80_0000;

  localparam logic [31:0] IDENT_VALUE = 32'h0000_0102;
  localparam logic [29:0] STATUS_LOW  = 30'h0000_2AAA;

  localparam logic [1:0] CODE_RUN  = 2'b11;
  localparam logic [1:0] CODE_IDLE = 2'b10;
  localparam logic [1:0] CODE_ERR  = 2'b01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERROR,
    ST_FETCH,
    ST_DECODE,
    ST_OPND_RD,
    ST_OPND_GET,
    ST_SRC_RD,
    ST_SRC_GET,
    ST_DST_RD,
    ST_DST_GET,
    ST_CP_RD,
    ST_CP_WR
  } cme_state_e;

endpackage

// File: rtl/cme_addr_check.sv
module cme_addr_check #(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned OFF_W      = 14,
  parameter logic [31:0] LOCAL_BASE = 32'hF000_0000
) (
  input  logic [31:0]      addr,
  input  logic [CNT_W-1:0] len,
  output logic             ok
);

  localparam int unsigned SUM_W = ((CNT_W > OFF_W) ? CNT_W : OFF_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << OFF_W;

  logic [SUM_W-1:0] span_end;
  logic             in_window;
  logic             aligned;

  assign span_end  = SUM_W'(addr[OFF_W-1:0]) + SUM_W'(len);
  assign in_window = (addr[31:OFF_W] == LOCAL_BASE[31:OFF_W]);
  assign aligned   = (addr[1:0] == 2'b00) && (len[1:0] == 2'b00);
  assign ok        = in_window && aligned && (span_end <= LIMIT);

endmodule

// File: rtl/cme_host_regs.sv
module cme_host_regs
  import cme_pkg::*;
#(
  parameter int unsigned OFF_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  input  logic [1:0]        run_code,
  output logic [31:0]       host_rdata,
  output logic              mem_en,
  output logic [OFF_W-3:0]  win_idx,
  output logic              soft_rst,
  output logic              start,
  output logic              win_wr
);

  logic             mem_en_d;
  logic [OFF_W-3:0] win_idx_d;
  logic             mem_en_ce;
  logic             win_idx_ce;

  assign soft_rst   = host_wr && (host_addr == REG_CTRL) && host_wdata[SOFT_RST_BIT];
  assign start      = host_wr && (host_addr == REG_START);
  assign win_wr     = host_wr && (host_addr == REG_WINDATA);

  assign mem_en_ce  = soft_rst || (host_wr && (host_addr == REG_MEMCTL));
  assign win_idx_ce = soft_rst || (host_wr && (host_addr == REG_WINADDR));

  always_comb begin
    mem_en_d  = host_wdata[0];
    win_idx_d = host_wdata[OFF_W-1:2];
    if (soft_rst) begin
      mem_en_d  = 1'b0;
      win_idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en  <= 1'b0;
      win_idx <= '0;
    end else begin
      if (mem_en_ce)  mem_en  <= mem_en_d;
      if (win_idx_ce) win_idx <= win_idx_d;
    end
  end

  always_comb begin
    unique case (host_addr)
      REG_CTRL:    host_rdata = {run_code, STATUS_LOW};
      REG_MEMCTL:  host_rdata = {31'd0, mem_en};
      REG_WINADDR: host_rdata = 32'({win_idx, 2'b00});
      REG_IDENT:   host_rdata = IDENT_VALUE;
      default:     host_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/cme_sequencer.sv
module cme_sequencer
  import cme_pkg::*;
#(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned OFF_W      = 14,
  parameter logic [31:0] LOCAL_BASE = 32'hF000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic [31:0]      start_ptr,
  input  logic             mem_en,
  input  logic [31:0]      lm_rdata,
  output logic [1:0]       run_code,
  output logic             eng_req,
  output logic             eng_we,
  output logic [OFF_W-3:0] eng_addr,
  output logic [31:0]      eng_wdata
);

  localparam logic [31:0] MOVE_VAR_MASK =
    (32'd1 << AND_BIT) | ((32'd1 << CNT_W) - 32'd1);
  localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(4);

  cme_state_e       state_q, state_d;
  logic [31:0]      pc_q, pc_d;
  logic [31:0]      src_q, src_d;
  logic [31:0]      dst_q, dst_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [31:0]      operand_q, operand_d;
  logic             and_q, and_d;
  logic             operand_ce;
  logic             pc_ok, src_ok, dst_ok;

  cme_addr_check #(.CNT_W(CNT_W), .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE)) pc_chk_i (
    .addr(pc_q), .len(WORD_BYTES), .ok(pc_ok)
  );
  cme_addr_check #(.CNT_W(CNT_W), .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE)) src_chk_i (
    .addr(src_q), .len(remain_q), .ok(src_ok)
  );
  cme_addr_check #(.CNT_W(CNT_W), .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE)) dst_chk_i (
    .addr(lm_rdata), .len(remain_q), .ok(dst_ok)
  );

  assign eng_wdata  = and_q ? (lm_rdata & operand_q) : lm_rdata;
  assign operand_ce = soft_rst || (state_q == ST_OPND_GET);

  always_comb begin
    unique case (state_q)
      ST_IDLE:  run_code = CODE_IDLE;
      ST_ERROR: run_code = CODE_ERR;
      default:  run_code = CODE_RUN;
    endcase
  end

  // Next-state and port request logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    src_d     = src_q;
    dst_d     = dst_q;
    remain_d  = remain_q;
    operand_d = lm_rdata;
    and_d     = and_q;
    eng_req   = 1'b0;
    eng_we    = 1'b0;
    eng_addr  = pc_q[OFF_W-1:2];

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          pc_d    = start_ptr;
          state_d = mem_en ? ST_FETCH : ST_ERROR;
        end
      end
      ST_ERROR: begin
        state_d = ST_ERROR;
      end
      ST_FETCH, ST_OPND_RD, ST_SRC_RD, ST_DST_RD: begin
        if (!pc_ok) begin
          state_d = ST_ERROR;
        end else begin
          eng_req = 1'b1;
          unique case (state_q)
            ST_FETCH:   state_d = ST_DECODE;
            ST_OPND_RD: state_d = ST_OPND_GET;
            ST_SRC_RD:  state_d = ST_SRC_GET;
            default:    state_d = ST_DST_GET;
          endcase
        end
      end
      ST_DECODE: begin
        pc_d = pc_q + 32'd4;
        if (lm_rdata == CMD_STOP) begin
          state_d = ST_IDLE;
        end else if (lm_rdata == CMD_INIT) begin
          state_d = ST_OPND_RD;
        end else if ((lm_rdata & ~MOVE_VAR_MASK) == CMD_MOVE) begin
          remain_d = lm_rdata[CNT_W-1:0];
          and_d    = lm_rdata[AND_BIT];
          state_d  = ST_SRC_RD;
        end else begin
          state_d = ST_ERROR;
        end
      end
      ST_OPND_GET: begin
        pc_d    = pc_q + 32'd4;
        state_d = ST_FETCH;
      end
      ST_SRC_GET: begin
        src_d   = lm_rdata;
        pc_d    = pc_q + 32'd4;
        state_d = ST_DST_RD;
      end
      ST_DST_GET: begin
        dst_d = lm_rdata;
        pc_d  = pc_q + 32'd4;
        if (!(src_ok && dst_ok)) begin
          state_d = ST_ERROR;
        end else if (remain_q == '0) begin
          state_d = ST_FETCH;
        end else begin
          state_d = ST_CP_RD;
        end
      end
      ST_CP_RD: begin
        eng_req  = 1'b1;
        eng_addr = src_q[OFF_W-1:2];
        state_d  = ST_CP_WR;
      end
      ST_CP_WR: begin
        eng_req  = 1'b1;
        eng_we   = 1'b1;
        eng_addr = dst_q[OFF_W-1:2];
        src_d    = src_q + 32'd4;
        dst_d    = dst_q + 32'd4;
        remain_d = remain_q - WORD_BYTES;
        state_d  = (remain_q == WORD_BYTES) ? ST_FETCH : ST_CP_RD;
      end
      default: state_d = ST_ERROR;
    endcase

    if (soft_rst) begin
      state_d   = ST_IDLE;
      operand_d = '0;
      and_d     = 1'b0;
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pc_q      <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      remain_q  <= '0;
      operand_q <= '0;
      and_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      src_q    <= src_d;
      dst_q    <= dst_d;
      remain_q <= remain_d;
      and_q    <= and_d;
      if (operand_ce) operand_q <= operand_d;
    end
  end

endmodule

// File: rtl/cmdlist_mover.sv
module cmdlist_mover
  import cme_pkg::*;
#(
  parameter int unsigned LOCAL_BYTES = 16384,
  parameter int unsigned CNT_W       = 20,
  parameter logic [31:0] LOCAL_BASE  = 32'hF000_0000,
  localparam int unsigned OFF_W      = $clog2(LOCAL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              lm_req,
  output logic              lm_we,
  output logic [OFF_W-3:0]  lm_addr,
  output logic [31:0]       lm_wdata,
  input  logic [31:0]       lm_rdata
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [1:0]       run_code;
  logic             mem_en;
  logic [OFF_W-3:0] win_idx;
  logic             soft_rst;
  logic             start;
  logic             win_wr;
  logic             eng_req;
  logic             eng_we;
  logic [OFF_W-3:0] eng_addr;
  logic [31:0]      eng_wdata;
  logic             busy;
  logic             win_go;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cme_host_regs #(.OFF_W(OFF_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .run_code   (run_code),
    .host_rdata (host_rdata),
    .mem_en     (mem_en),
    .win_idx    (win_idx),
    .soft_rst   (soft_rst),
    .start      (start),
    .win_wr     (win_wr)
  );

  cme_sequencer #(.CNT_W(CNT_W), .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .soft_rst  (soft_rst),
    .start     (start),
    .start_ptr (host_wdata),
    .mem_en    (mem_en),
    .lm_rdata  (lm_rdata),
    .run_code  (run_code),
    .eng_req   (eng_req),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata)
  );

  // Engine owns the port while running; otherwise enabled window writes use it
  assign busy     = (run_code == CODE_RUN);
  assign win_go   = win_wr && mem_en && !busy;
  assign lm_req   = busy ? eng_req   : win_go;
  assign lm_we    = busy ? eng_we    : win_go;
  assign lm_addr  = busy ? eng_addr  : win_idx;
  assign lm_wdata = busy ? eng_wdata : host_wdata;

endmodule

// File: rtl/cmdlist_mover_checker.sv
module cmdlist_mover_checker
  import cme_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              start,
  input logic              win_wr,
  input logic              mem_en,
  input logic [1:0]        run_code,
  input logic              lm_req,
  input logic [REG_AW-1:0] host_addr,
  input logic [31:0]       host_rdata
);

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_code != 2'b00);

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_code == CODE_ERR && !soft_rst) |=> (run_code == CODE_ERR));

  assert_start_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run_code == CODE_IDLE && !soft_rst) |=> (run_code != CODE_IDLE));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (run_code == CODE_IDLE && !mem_en));

  assert_port_quiet_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_code != CODE_RUN && !mem_en) |-> !lm_req);

  assert_port_quiet_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_code != CODE_RUN && !win_wr) |-> !lm_req);

  assert_ident_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == REG_IDENT) |-> (host_rdata == IDENT_VALUE));

endmodule

bind cmdlist_mover cmdlist_mover_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .soft_rst   (soft_rst),
  .start      (start),
  .win_wr     (win_wr),
  .mem_en     (mem_en),
  .run_code   (run_code),
  .lm_req     (lm_req),
  .host_addr  (host_addr),
  .host_rdata (host_rdata)
);

// File: tb/cmdlist_mover_tb_top.sv
module cmdlist_mover_tb_top;

  localparam logic [31:0] BASE     = 32'hF000_0000;
  localparam logic [31:0] ST_READY = 32'h8000_2AAA;
  localparam logic [31:0] ST_ERR   = 32'h4000_2AAA;

  logic        clk;
  logic        rst_n;
  logic        host_wr;
  logic [2:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        lm_req;
  logic        lm_we;
  logic [11:0] lm_addr;
  logic [31:0] lm_wdata;
  logic [31:0] lm_rdata;
  logic [31:0] mem [0:4095];

  int checks;
  int failures;

  cmdlist_mover dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .lm_req(lm_req),
    .lm_we(lm_we), .lm_addr(lm_addr), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Local memory model: one-cycle read latency
  always @(posedge clk) begin
    if (lm_req) begin
      if (lm_we) mem[lm_addr] <= lm_wdata;
      else       lm_rdata <= mem[lm_addr];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic ww(input logic [31:0] off, input logic [31:0] d);
    hw(3'd3, off);
    hw(3'd4, d);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    int n;
    n = 0;
    rd(3'd0, s);
    while (s[31:30] == 2'b11 && n < 20000) begin
      rd(3'd0, s);
      n++;
    end
    if (n >= 20000) check("R4 run did not end", s, ST_READY);
  endtask

  function automatic logic [31:0] mv(input logic andf, input logic [19:0] cnt);
    return 32'h0A80_0000 | (32'(andf) << 21) | 32'(cnt);
  endfunction

  task automatic prog_move(input logic [31:0] op, input logic [31:0] mvw,
                           input logic [31:0] src, input logic [31:0] dst);
    ww(32'h000, 32'h0600_0000);
    ww(32'h004, op);
    ww(32'h008, mvw);
    ww(32'h00C, src);
    ww(32'h010, dst);
    ww(32'h014, 32'h0000_0000);
  endtask

  task automatic recover();
    hw(3'd0, 32'h0001_0000);
    hw(3'd2, 32'h1);
  endtask

  task automatic expect_error(input string req);
    logic [31:0] s;
    wait_done();
    rd(3'd0, s);
    check(req, s, ST_ERR);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] s;
    checks = 0; failures = 0;
    host_wr = 1'b0; host_addr = 3'd0; host_wdata = 32'd0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, s); check("R1 status", s, ST_READY);
    rd(3'd5, s); check("R1 ident", s, 32'h0000_0102);
    rd(3'd2, s); check("R1 memctl", s, 32'd0);
    check("R1 port idle", 32'(lm_req), 32'd0);

    // R11 identity is read-only
    hw(3'd5, 32'h0);
    rd(3'd5, s); check("R11 ident after write", s, 32'h0000_0102);

    // R2 window disabled then enabled
    hw(3'd3, 32'h40);
    rd(3'd3, s); check("R2 window address readback", s, 32'h40);
    @(negedge clk); host_wr = 1'b1; host_addr = 3'd4; host_wdata = 32'h7777_0000;
    #1 check("R2 disabled no request", 32'(lm_req), 32'd0);
    @(negedge clk); host_wr = 1'b0;
    hw(3'd2, 32'h1);
    rd(3'd2, s); check("R2 memctl enabled", s, 32'h1);
    @(negedge clk); host_wr = 1'b1; host_addr = 3'd4; host_wdata = 32'h1111_2222;
    #1 check("R2 same-cycle write", {lm_req, lm_we, 18'd0, lm_addr}, {2'b11, 18'd0, 12'h010});
    @(negedge clk); host_wr = 1'b0;
    check("R2 word stored", mem[12'h010], 32'h1111_2222);

    // R5 R6 R7 R4 sweep over counts 0..8 words, AND and plain alternating
    for (int i = 0; i < 9; i++) ww(32'h400 + 32'(i) * 4, 32'h9E37_79B9 * 32'(i + 1));
    for (int n = 0; n <= 8; n++) begin
      logic [31:0] op;
      logic andf;
      op = 32'hF0F0_FF0F ^ (32'(n) << 8);
      andf = (n % 2 == 0);
      for (int i = 0; i < 9; i++) ww(32'h800 + 32'(i) * 4, 32'hDEAD_0000 + 32'(i));
      prog_move(op, mv(andf, 20'(n * 4)), BASE + 32'h400, BASE + 32'h800);
      hw(3'd1, BASE);
      rd(3'd0, s); check("R3 running after start", 32'(s[31:30]), 32'd3);
      wait_done();
      rd(3'd0, s); check("R4 idle after stop", s, ST_READY);
      for (int i = 0; i < 9; i++) begin
        logic [31:0] sv, ev;
        sv = 32'h9E37_79B9 * 32'(i + 1);
        if (i >= n)    ev = 32'hDEAD_0000 + 32'(i);
        else if (andf) ev = sv & op;
        else           ev = sv;
        if (andf) check("R7 R5 AND copy word", mem[12'h200 + 12'(i)], ev);
        else      check("R6 plain copy word", mem[12'h200 + 12'(i)], ev);
      end
    end

    // R6 overlapping forward copy replicates first word (ascending order)
    ww(32'h400, 32'hABCD_0001);
    for (int i = 1; i < 6; i++) ww(32'h400 + 32'(i) * 4, 32'h0);
    prog_move(32'hFFFF_FFFF, mv(1'b0, 20'd16), BASE + 32'h400, BASE + 32'h404);
    hw(3'd1, BASE);
    wait_done();
    for (int i = 1; i < 5; i++) check("R6 ascending overlap", mem[12'h100 + 12'(i)], 32'hABCD_0001);
    check("R6 word past run", mem[12'h105], 32'h0);

    // R12 window write while running is dropped
    ww(32'h3800, 32'h5555_AAAA);
    ww(32'h13FC, 32'hCAFE_F00D);
    prog_move(32'h0, mv(1'b0, 20'h400), BASE + 32'h1000, BASE + 32'h2000);
    hw(3'd1, BASE);
    hw(3'd3, 32'h3800);
    hw(3'd4, 32'h1234_5678);
    wait_done();
    check("R12 dropped window write", mem[12'hE00], 32'h5555_AAAA);
    check("R6 long copy last word", mem[12'h8FF], 32'hCAFE_F00D);

    // R10 soft reset aborts a run
    ww(32'h2BFC, 32'h0BAD_F00D);
    prog_move(32'h0, mv(1'b0, 20'h400), BASE + 32'h1000, BASE + 32'h2800);
    hw(3'd1, BASE);
    repeat (20) @(negedge clk);
    hw(3'd0, 32'h0001_0000);
    rd(3'd0, s); check("R10 status after soft reset", s, ST_READY);
    rd(3'd2, s); check("R10 memctl cleared", s, 32'h0);
    rd(3'd3, s); check("R10 window address cleared", s, 32'h0);
    repeat (600) @(negedge clk);
    check("R10 aborted tail untouched", mem[12'hAFF], 32'h0BAD_F00D);

    // R3 start with memory disabled
    hw(3'd1, BASE);
    rd(3'd0, s); check("R3 start with memory off", s, ST_ERR);
    recover();

    // R8 unknown opcode, sticky, start ignored
    ww(32'h000, 32'h1234_5678);
    hw(3'd1, BASE);
    expect_error("R8 unknown opcode");
    hw(3'd1, BASE);
    rd(3'd0, s); check("R8 start ignored in error", s, ST_ERR);
    recover();
    rd(3'd0, s); check("R10 recovery from error", s, ST_READY);

    // R8 move pattern with bit 20 set
    ww(32'h800, 32'h0000_AAAA);
    prog_move(32'hFFFF_FFFF, mv(1'b1, 20'd4) | 32'h0010_0000, BASE + 32'h400, BASE + 32'h800);
    hw(3'd1, BASE);
    expect_error("R8 bit20 move");
    check("R8 no write", mem[12'h200], 32'h0000_AAAA);
    recover();

    // R9 source outside window
    prog_move(32'hFFFF_FFFF, mv(1'b1, 20'd8), 32'h1000_0000, BASE + 32'h800);
    hw(3'd1, BASE);
    expect_error("R9 source outside window");
    check("R9 no write src", mem[12'h200], 32'h0000_AAAA);
    recover();

    // R9 run crossing window end
    prog_move(32'hFFFF_FFFF, mv(1'b0, 20'd16), BASE + 32'h400, BASE + 32'h3FF8);
    hw(3'd1, BASE);
    expect_error("R9 destination run past end");
    recover();

    // R9 count not multiple of 4
    prog_move(32'hFFFF_FFFF, mv(1'b0, 20'd6), BASE + 32'h400, BASE + 32'h800);
    hw(3'd1, BASE);
    expect_error("R9 odd count");
    check("R9 no write count", mem[12'h200], 32'h0000_AAAA);
    recover();

    // R9 misaligned destination
    prog_move(32'hFFFF_FFFF, mv(1'b0, 20'd4), BASE + 32'h400, BASE + 32'h802);
    hw(3'd1, BASE);
    expect_error("R9 misaligned destination");
    check("R9 no write align", mem[12'h200], 32'h0000_AAAA);
    recover();

    // R9 program start outside window
    hw(3'd1, 32'h2000_0000);
    expect_error("R9 fetch outside window");
    recover();

    // R9 program running off the end of the window
    ww(32'h3FFC, 32'h0600_0000);
    hw(3'd1, BASE + 32'h3FFC);
    expect_error("R9 fetch past end");
    recover();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule